// File: doc/BRIEF.md
# Auto-Incrementing Byte Memory Target

This block is a memory device that takes whole transactions, not serial bits. Each transaction is one of three kinds: an address load, a data read or a data write. The device keeps a 32-bit address pointer and an array of bytes.

An address load sets the pointer. Its length must match the configured address width, which is 1 to 4 bytes. A read or a write moves 1 to 8 bytes. The data is right-justified in a 64-bit word, and the pointer then steps forward by the number of bytes moved.

A controller presents one transaction per cycle with `op_valid`. Exactly one cycle later it gets a response with an error flag. A read response also carries the data. Rejected transactions leave both the pointer and the array untouched.

Top module: `mt_target`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cur_ptr` becomes 0 and `rsp_valid` becomes 0.
- R2: An address load (`op_kind` = 1) is accepted when `cfg_addr_bytes` is 1 to 4 and `op_count` equals it. On acceptance, `cur_ptr` is loaded with the low `op_count` bytes of `op_data`, zero-extended, and `rsp_err` is 0.
- R3: An address load whose `op_count` differs from `cfg_addr_bytes` is rejected with `rsp_err` = 1 and `cur_ptr` unchanged. The same applies whenever `cfg_addr_bytes` is 0 or greater than 4.
- R4: A read (`op_kind` = 2) of N bytes returns them right-justified in `rsp_data`, with all bytes above them zero. The byte at the pointer is the most significant of the N bytes. `cur_ptr` then increases by N.
- R5: A write (`op_kind` = 3) of N bytes stores byte N-1 of `op_data` (bits 8N-1:8N-8) at the pointer. Each next lower byte goes to the next address. `cur_ptr` then increases by N.
- R6: A read or write with `op_count` of 0 or more than 8 is rejected with `rsp_err` = 1. The array, the pointer and `rsp_data` (which reads 0) are left unaffected.
- R7: A read or write with pointer + N greater than DEPTH is rejected with `rsp_err` = 1, and nothing is transferred. A transfer that ends exactly at DEPTH is accepted.
- R8: Every cycle with `op_valid` high yields exactly one cycle of `rsp_valid` on the next cycle, including back-to-back operations. `op_kind` = 0 is rejected with `rsp_err` = 1.
- R9: Any rejected operation returns `rsp_data` = 0 and leaves `cur_ptr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr_bytes | input | 3 | Configured address width in bytes (valid 1..4) |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 reserved, 1 address load, 2 read, 3 write |
| op_count | input | 4 | Byte count of the operation |
| op_data | input | 64 | Address or write data, right-justified |
| rsp_valid | output | 1 | Response for the operation of the previous cycle |
| rsp_err | output | 1 | Operation was rejected |
| rsp_data | output | 64 | Read data, right-justified, zero otherwise |
| cur_ptr | output | 32 | Current address pointer |

## Verification
Two mixes are used:
- A write of eight bytes is read back in two pieces of three and five bytes. This separates byte ordering within an operation from the carry of the pointer between operations.
- Address loads are tried under each configured width, with counts that are one too few and one too many, and with upper data bits set. This shows truncation as distinct from count checking.

Transfers are also placed ending exactly at the array's end and one byte beyond it, and from a pointer far outside the array, to probe the range check. Illegal counts are sent between a known write and its readback, to show they leave storage untouched.

// File: rtl/mt_pkg.sv
// Shared types for the byte memory target.
// Assumes a byte-wide array and at most eight bytes per transfer.
package mt_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ADDR  = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = 8 * MAX_BYTES;
    localparam int PTR_W     = 32;
    localparam int CNT_W     = 4;
    localparam int CFG_W     = 3;
    localparam int MAX_ABYTES = 4;
endpackage

// File: rtl/mt_decode.sv
// Operation checker and pointer calculator.
// Purely combinational. It decides whether an operation is legal and
// what the pointer becomes. Assumes DEPTH fits in 32 bits.
module mt_decode
    import mt_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  op_e                kind,
    input  logic [CNT_W-1:0]   count,
    input  logic [CFG_W-1:0]   cfg,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [PTR_W-1:0]   addr_in,
    output logic               err,
    output logic [PTR_W-1:0]   ptr_next,
    output logic               rd_go,
    output logic               wr_go
);
    localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(DEPTH);

    logic             cfg_ok;
    logic             cnt_ok;
    logic             span_ok;
    logic [PTR_W:0]   span_end;
    logic [PTR_W-1:0] addr_val;

    // Range and count checks for every operation kind.
    always_comb begin
        cfg_ok   = (cfg >= CFG_W'(1)) && (cfg <= CFG_W'(MAX_ABYTES));
        cnt_ok   = (count != '0) && (count <= CNT_W'(MAX_BYTES));
        span_end = {1'b0, ptr} + (PTR_W+1)'(count);
        span_ok  = span_end <= LIMIT;
    end

    // Keep only the configured number of low address bytes.
    always_comb begin
        case (count)
            CNT_W'(1): addr_val = {24'd0, addr_in[7:0]};
            CNT_W'(2): addr_val = {16'd0, addr_in[15:0]};
            CNT_W'(3): addr_val = {8'd0, addr_in[23:0]};
            CNT_W'(4): addr_val = addr_in;
            default:   addr_val = '0;
        endcase
    end

    // Final accept decision and next pointer.
    always_comb begin
        err      = 1'b1;
        ptr_next = ptr;
        rd_go    = 1'b0;
        wr_go    = 1'b0;
        case (kind)
            OP_ADDR: if (cfg_ok && (count == CNT_W'(cfg))) begin
                err      = 1'b0;
                ptr_next = addr_val;
            end
            OP_READ: if (cnt_ok && span_ok) begin
                err      = 1'b0;
                rd_go    = 1'b1;
                ptr_next = span_end[PTR_W-1:0];
            end
            OP_WRITE: if (cnt_ok && span_ok) begin
                err      = 1'b0;
                wr_go    = 1'b1;
                ptr_next = span_end[PTR_W-1:0];
            end
            default: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/mt_array.sv
// Byte storage with eight lanes.
// Lane i addresses base+i. The lowest address maps to the most significant
// byte of the transfer. Assumes DEPTH is a power of two and that the caller
// only enables a write whose range is legal. Storage is not reset.
module mt_array
    import mt_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [$clog2(DEPTH)-1:0]  base,
    input  logic [CNT_W-1:0]          count,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] lane_addr [MAX_BYTES];
    int            ncnt;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        assign lane_addr[g] = base + AW'(g);
    end

    // Clamp the count so that part selects stay inside the word.
    always_comb ncnt = (count > CNT_W'(MAX_BYTES)) ? 0 : int'(count);

    // Gather the addressed bytes, right-justified, lowest address on top.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < MAX_BYTES; i++)
            if (i < ncnt) rdata[8*(ncnt-1-i) +: 8] = mem[lane_addr[i]];
    end

    // Scatter the write bytes into the lanes that take part.
    always_ff @(posedge clk) begin
        if (wr_en)
            for (int i = 0; i < MAX_BYTES; i++)
                if (i < ncnt) mem[lane_addr[i]] <= wdata[8*(ncnt-1-i) +: 8];
    end
endmodule

// File: rtl/mt_target.sv
// Auto-incrementing byte memory target, top level.
// Takes one operation per cycle and answers one cycle later. The pointer
// and the response are registered. Assumes DEPTH is a power of two.
module mt_target
    import mt_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cfg_addr_bytes,
    input  logic        op_valid,
    input  logic [1:0]  op_kind,
    input  logic [3:0]  op_count,
    input  logic [63:0] op_data,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [63:0] rsp_data,
    output logic [31:0] cur_ptr
);
    localparam int AW = $clog2(DEPTH);

    logic              dec_err;
    logic [PTR_W-1:0]  ptr_next;
    logic              rd_go;
    logic              wr_go;
    logic [DATA_W-1:0] arr_rdata;
    op_e               kind;

    assign kind = op_e'(op_kind);

    mt_decode #(.DEPTH(DEPTH)) u_dec (
        .kind     (kind),
        .count    (op_count),
        .cfg      (cfg_addr_bytes),
        .ptr      (cur_ptr),
        .addr_in  (op_data[PTR_W-1:0]),
        .err      (dec_err),
        .ptr_next (ptr_next),
        .rd_go    (rd_go),
        .wr_go    (wr_go)
    );

    mt_array #(.DEPTH(DEPTH)) u_arr (
        .clk   (clk),
        .wr_en (op_valid && wr_go),
        .base  (cur_ptr[AW-1:0]),
        .count (op_count),
        .wdata (op_data),
        .rdata (arr_rdata)
    );

    // Register the pointer and the response of each operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr   <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= op_valid;
            if (op_valid) begin
                cur_ptr  <= ptr_next;
                rsp_err  <= dec_err;
                rsp_data <= rd_go ? arr_rdata : '0;
            end
        end
    end
endmodule

// File: rtl/mt_target_chk.sv
// Property checker for mt_target, attached with bind.
// Observes ports only.
module mt_target_chk #(
    parameter int DEPTH = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  cfg_addr_bytes,
    input logic        op_valid,
    input logic [1:0]  op_kind,
    input logic [3:0]  op_count,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [63:0] rsp_data,
    input logic [31:0] cur_ptr
);
    logic rdwr;
    logic over_end;

    assign rdwr     = op_valid && (op_kind[1] == 1'b1);
    assign over_end = ({1'b0, cur_ptr} + 33'(op_count)) > 33'(DEPTH);

    a_r8_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> rsp_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !rsp_valid);
    a_r2_legal_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd1 && cfg_addr_bytes >= 3'd1 &&
         cfg_addr_bytes <= 3'd4 && op_count == 4'(cfg_addr_bytes)) |=> !rsp_err);
    a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ($stable(cur_ptr) && rsp_data == 64'd0));
    a_r6_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rdwr && (op_count == 4'd0 || op_count > 4'd8)) |=> rsp_err);
    a_r7_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (rdwr && op_count != 4'd0 && op_count <= 4'd8 && over_end) |=> rsp_err);
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        rdwr |=> (rsp_err || cur_ptr == $past(cur_ptr) + 32'($past(op_count))));
    a_r8_idle_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(cur_ptr));
endmodule

bind mt_target mt_target_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_addr_bytes (cfg_addr_bytes),
    .op_valid       (op_valid),
    .op_kind        (op_kind),
    .op_count       (op_count),
    .rsp_valid      (rsp_valid),
    .rsp_err        (rsp_err),
    .rsp_data       (rsp_data),
    .cur_ptr        (cur_ptr)
);

// File: tb/mt_target_test.sv
// Scoreboard bench for mt_target.
// The driver models the expected result and queues it. The monitor
// compares each response against the queue.
module mt_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int WD_CYCLES  = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_addr_bytes = 3'd1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [3:0]  op_count = 4'd0;
    logic [63:0] op_data = 64'd0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_data;
    logic [31:0] cur_ptr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic        q_err  [$];
    logic [63:0] q_data [$];
    logic [31:0] q_ptr  [$];
    string       q_tag  [$];

    logic [7:0]  mdl_mem [DEPTH];
    longint      mdl_ptr = 0;

    mt_target #(.DEPTH(DEPTH)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_addr_bytes (cfg_addr_bytes),
        .op_valid       (op_valid),
        .op_kind        (op_kind),
        .op_count       (op_count),
        .op_data        (op_data),
        .rsp_valid      (rsp_valid),
        .rsp_err        (rsp_err),
        .rsp_data       (rsp_data),
        .cur_ptr        (cur_ptr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string got, input string exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %s expected %s", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Driver: present one operation for one cycle and queue its expectation.
    task automatic issue(input logic [1:0] k, input int n, input int cfg,
                         input logic [63:0] d, input string tag);
        logic        e;
        logic [63:0] xd;
        longint      np;
        e  = 1'b0;
        xd = 64'd0;
        np = mdl_ptr;
        case (k)
            2'd1: begin
                if (cfg >= 1 && cfg <= 4 && n == cfg)
                    np = (n == 4) ? longint'(d[31:0]) : longint'(d & ((64'd1 << (8*n)) - 64'd1));
                else e = 1'b1;
            end
            2'd2, 2'd3: begin
                if (n >= 1 && n <= 8 && mdl_ptr + n <= DEPTH) begin
                    for (int i = 0; i < n; i++) begin
                        if (k == 2'd2) xd = (xd << 8) | 64'(mdl_mem[mdl_ptr + i]);
                        else mdl_mem[mdl_ptr + i] = d[8*(n-1-i) +: 8];
                    end
                    np = mdl_ptr + n;
                end else e = 1'b1;
            end
            default: e = 1'b1;
        endcase
        mdl_ptr = np;
        q_err.push_back(e);
        q_data.push_back(xd);
        q_ptr.push_back(32'(np));
        q_tag.push_back(tag);
        @(negedge clk);
        op_valid       = 1'b1;
        op_kind        = k;
        op_count       = 4'(n);
        op_data        = d;
        cfg_addr_bytes = 3'(cfg);
    endtask

    task automatic go_idle(input int cycles);
        @(negedge clk);
        op_valid = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    // Monitor: compare every response with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            if (q_err.size() == 0) begin
                check(1'b0, "R8 unexpected response", "rsp_valid=1", "none");
            end else begin
                logic        e;
                logic [63:0] xd;
                logic [31:0] xp;
                string       t;
                e  = q_err.pop_front();
                xd = q_data.pop_front();
                xp = q_ptr.pop_front();
                t  = q_tag.pop_front();
                check(rsp_err == e && rsp_data == xd && cur_ptr == xp, t,
                      $sformatf("err=%0b data=%h ptr=%h", rsp_err, rsp_data, cur_ptr),
                      $sformatf("err=%0b data=%h ptr=%h", e, xd, xp));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", "timeout", "completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cur_ptr == 32'd0 && rsp_valid == 1'b0, "R1 reset state",
              $sformatf("ptr=%h v=%0b", cur_ptr, rsp_valid), "ptr=0 v=0");
        rst_n = 1'b1;

        issue(2'd1, 2, 2, 64'h0000_0000_0000_0010, "R2 addr load width 2");
        issue(2'd3, 8, 2, 64'h0102_0304_0506_0708, "R5 write 8 bytes");
        issue(2'd1, 2, 2, 64'h0000_0000_0000_0010, "R2 reload pointer");
        issue(2'd2, 3, 2, 64'd0, "R4 read 3 bytes");
        issue(2'd2, 5, 2, 64'd0, "R4 read 5 bytes continues");
        issue(2'd1, 1, 2, 64'h0000_0000_0000_0044, "R3 addr count too small");
        issue(2'd1, 3, 2, 64'h0000_0000_0000_0044, "R3 addr count too large");
        go_idle(2);

        issue(2'd1, 4, 4, 64'hFFFF_FF00_0000_00FC, "R2 addr width 4 drops high bits");
        issue(2'd3, 4, 4, 64'h0000_0000_AABB_CCDD, "R7 write ending at array end");
        issue(2'd2, 1, 4, 64'd0, "R7 read one past end");
        issue(2'd1, 4, 4, 64'h0000_0000_0000_00FC, "R2 reload to FC");
        issue(2'd2, 4, 4, 64'd0, "R4 read back end bytes");
        issue(2'd1, 4, 4, 64'h0000_0000_0000_00FE, "R2 load FE");
        issue(2'd3, 3, 4, 64'h0000_0000_0011_2233, "R7 write crossing end");
        issue(2'd2, 2, 4, 64'd0, "R7 array unchanged after rejected write");

        issue(2'd1, 1, 1, 64'h0000_0000_0000_1234, "R2 addr width 1 truncates");
        issue(2'd3, 2, 1, 64'h0000_0000_0000_5566, "R5 write 2 bytes");
        issue(2'd1, 1, 1, 64'h0000_0000_0000_0034, "R2 reload 34");
        issue(2'd3, 0, 1, 64'h0000_0000_0000_9999, "R6 write count zero");
        issue(2'd3, 9, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R6 write count nine");
        issue(2'd2, 15, 1, 64'd0, "R6 read count fifteen");
        issue(2'd2, 2, 1, 64'd0, "R6 storage untouched by bad counts");
        go_idle(1);

        issue(2'd1, 0, 0, 64'd0, "R3 config zero rejected");
        issue(2'd1, 5, 5, 64'd5, "R3 config five rejected");
        issue(2'd0, 1, 1, 64'd0, "R8 reserved kind rejected");
        issue(2'd1, 4, 4, 64'h0000_0000_8000_0000, "R2 far pointer");
        issue(2'd2, 1, 4, 64'd0, "R7 read far outside array");
        issue(2'd3, 8, 4, 64'h1111_1111_1111_1111, "R9 rejected write keeps pointer");
        go_idle(4);

        check(q_err.size() == 0, "R8 every operation answered",
              $sformatf("%0d pending", q_err.size()), "0 pending");
        done = 1'b1;
        finish_run();
    end
endmodule